// File: doc/BRIEF.md
# Display Output Interrupt Register Bank

This block holds the interrupt state of a display output wrapper. Hardware event sources, such as the end of a video frame, send single-cycle pulses. Each pulse is latched into a raw event register, whether or not that event is enabled. An enable vector selects which latched events raise the single level interrupt output. Software reads a masked status view to find the events that are both pending and enabled. It acknowledges events by writing ones to the status register.

The enable vector is never written directly. One register alias sets enable bits and a second alias clears them, so two software agents can change their own enable bits without a read-modify-write race. A wake-enable vector sits next to the enables as a plain read/write register. The bus side is a simple strobe interface: a write is one cycle with the write strobe asserted, and read data follows the word address combinationally. Event bit `FRAME_DONE_BIT` is reserved for the dedicated frame-done input.

Top module: `disp_irq_bank`

## Requirements
- R1: After reset the raw events, the enables and the wake enables are all zero, `irqOut` is low, and every register reads zero.
- R2: A one on `evtPulse[b]` at a clock edge sets raw bit b at that edge, whether or not it is enabled. Word address 0 reads the raw event vector.
- R3: Word address 1 reads the masked status, which is the raw events ANDed with the enables.
- R4: A write to word address 2 sets every enable bit whose `wrData` bit is one and leaves the other enable bits unchanged. Reads at addresses 2 and 3 both return the enable vector.
- R5: A write to word address 3 clears every enable bit whose `wrData` bit is one and leaves the other enable bits unchanged.
- R6: A write to word address 1 clears every raw bit whose `wrData` bit is one. Zero bits have no effect, and a read in the next cycle shows the cleared value.
- R7: When an event pulse and a status clear hit the same bit at the same edge, the event wins and the raw bit stays one.
- R8: Word address 4 is the wake-enable register: a plain read/write register whose writes leave the raw events, the enables and `irqOut` unchanged.
- R9: `irqOut` is high exactly while some bit is both raw-set and enabled. It follows the register state in the same cycle, with no further delay.
- R10: Writes to word address 0 and to unmapped addresses 5 to 7 change nothing. Unmapped addresses read zero, and data bits at or above `NUM_EVENTS` read zero and are ignored on write.
- R11: A pulse on `frameDone` sets raw bit `FRAME_DONE_BIT` (default 0), just as a pulse on that `evtPulse` bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Word address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| evtPulse | input | NUM_EVENTS | Single-cycle event pulses |
| frameDone | input | 1 | Frame-done event pulse |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default parameters: eight events, frame done on bit 0, and a 32-bit data bus. This leaves 24 upper data bits that must read zero and be ignored, which exercises the masking boundary. With eight events, the stimulus can place several enabled and disabled events at once, so the raw and masked views differ in the same vector. All five word addresses and the unmapped holes can be reached from the three-bit address.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_RAW   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_WAKE  = 3'd4;

  typedef enum logic [2:0] {
    SEL_RAW,
    SEL_STAT,
    SEL_EN,
    SEL_WAKE,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic clrEvt;
    logic setEn;
    logic clrEn;
    logic loadWake;
  } wrStrobe_t;

endpackage

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobe_t         stb,
  output rdSel_e            rdSel
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        OFS_STAT:  stb.clrEvt   = 1'b1;
        OFS_ENSET: stb.setEn    = 1'b1;
        OFS_ENCLR: stb.clrEn    = 1'b1;
        OFS_WAKE:  stb.loadWake = 1'b1;
        default:   stb          = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      OFS_RAW:   rdSel = SEL_RAW;
      OFS_STAT:  rdSel = SEL_STAT;
      OFS_ENSET: rdSel = SEL_EN;
      OFS_ENCLR: rdSel = SEL_EN;
      OFS_WAKE:  rdSel = SEL_WAKE;
      default:   rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/disp_irq_dp.sv
module disp_irq_dp
  import disp_irq_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wrStrobe_t             stb,
  input  rdSel_e                rdSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_EVENTS-1:0] evtVec,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_EVENTS-1:0] rawVec,
  output logic [NUM_EVENTS-1:0] enVec,
  output logic [NUM_EVENTS-1:0] wakeVec,
  output logic                  irqOut
);

  logic [NUM_EVENTS-1:0] wrMask;
  logic [NUM_EVENTS-1:0] rawQ, rawNext;
  logic [NUM_EVENTS-1:0] enQ, enNext;
  logic [NUM_EVENTS-1:0] wakeQ;
  logic [NUM_EVENTS-1:0] pendVec;

  assign wrMask = wrData[NUM_EVENTS-1:0];

  for (genvar b = 0; b < NUM_EVENTS; b++) begin : g_bit
    // an incoming pulse outranks a clear on the same bit
    assign rawNext[b] = evtVec[b] | (rawQ[b] & ~(stb.clrEvt & wrMask[b]));
    assign enNext[b]  = (enQ[b] | (stb.setEn & wrMask[b])) & ~(stb.clrEn & wrMask[b]);
    assign pendVec[b] = rawQ[b] & enQ[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= '0;
      enQ   <= '0;
      wakeQ <= '0;
    end else begin
      rawQ <= rawNext;
      enQ  <= enNext;
      if (stb.loadWake) wakeQ <= wrMask;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_RAW:  rdData[NUM_EVENTS-1:0] = rawQ;
      SEL_STAT: rdData[NUM_EVENTS-1:0] = pendVec;
      SEL_EN:   rdData[NUM_EVENTS-1:0] = enQ;
      SEL_WAKE: rdData[NUM_EVENTS-1:0] = wakeQ;
      default:  rdData = '0;
    endcase
  end

  assign irqOut  = |pendVec;
  assign rawVec  = rawQ;
  assign enVec   = enQ;
  assign wakeVec = wakeQ;

endmodule

// File: rtl/disp_irq_bank.sv
module disp_irq_bank
  import disp_irq_pkg::*;
#(
  parameter int NUM_EVENTS     = 8,
  parameter int DATA_W         = 32,
  parameter int FRAME_DONE_BIT = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_EVENTS-1:0] evtPulse,
  input  logic                  frameDone,
  output logic                  irqOut
);

  localparam logic [NUM_EVENTS-1:0] FD_ONEHOT = NUM_EVENTS'(1) << FRAME_DONE_BIT;

  wrStrobe_t             stb;
  rdSel_e                rdSel;
  logic [NUM_EVENTS-1:0] evtAll;
  logic [NUM_EVENTS-1:0] rawVec;
  logic [NUM_EVENTS-1:0] enVec;
  logic [NUM_EVENTS-1:0] wakeVec;

  assign evtAll = evtPulse | (FD_ONEHOT & {NUM_EVENTS{frameDone}});

  disp_irq_ctrl u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  disp_irq_dp #(
    .NUM_EVENTS (NUM_EVENTS),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .evtVec  (evtAll),
    .rdData  (rdData),
    .rawVec  (rawVec),
    .enVec   (enVec),
    .wakeVec (wakeVec),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/disp_irq_bank_chk.sv
module disp_irq_bank_chk #(
  parameter int NUM_EVENTS = 8,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [2:0]            addr,
  input logic [DATA_W-1:0]     wrData,
  input logic [NUM_EVENTS-1:0] evtAll,
  input logic [NUM_EVENTS-1:0] rawVec,
  input logic [NUM_EVENTS-1:0] enVec,
  input logic                  irqOut
);

  logic [NUM_EVENTS-1:0] m;
  assign m = wrData[NUM_EVENTS-1:0];

  // events land in raw, also over a same-edge clear
  assert_evt_latch_R2_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evtAll != '0) |=> ((rawVec & $past(evtAll)) == $past(evtAll)));

  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2) |=> ((enVec & $past(m)) == $past(m)) &&
                               ((enVec & ~$past(m)) == ($past(enVec) & ~$past(m))));

  assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=> ((enVec & $past(m)) == '0) &&
                               ((enVec & ~$past(m)) == ($past(enVec) & ~$past(m))));

  assert_evt_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd1 && evtAll == '0) |=> ((rawVec & $past(m)) == '0));

  assert_wake_isolated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd4) |=> (enVec == $past(enVec)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((rawVec == '0) || (enVec == '0)) |-> !irqOut);

  assert_raw_ro_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == 3'd0 || addr > 3'd4) && evtAll == '0) |=>
      (rawVec == $past(rawVec)) && (enVec == $past(enVec)));

endmodule

bind disp_irq_bank disp_irq_bank_chk #(
  .NUM_EVENTS (NUM_EVENTS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .evtAll (evtAll),
  .rawVec (rawVec),
  .enVec  (enVec),
  .irqOut (irqOut)
);

// File: tb/disp_irq_bank_tb.sv
`timescale 1ns/100ps
module disp_irq_bank_tb;

  localparam int NE = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NE-1:0] evtPulse = '0;
  logic          frameDone = 1'b0;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  disp_irq_bank #(.NUM_EVENTS(NE), .DATA_W(DW), .FRAME_DONE_BIT(0)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evtPulse(evtPulse), .frameDone(frameDone), .irqOut(irqOut)
  );

  typedef struct packed {
    logic       we;
    logic [2:0] wa;
    logic [7:0] wd;
    logic [7:0] ev;
    logic [2:0] ra;
    logic [7:0] expRd;
    logic       expIrq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 8'h00, 8'h05, 3'd0, 8'h05, 1'b0}, // R2 latch while disabled
    '{1'b1, 3'd2, 8'h04, 8'h00, 3'd1, 8'h04, 1'b1}, // R3 R4 R9
    '{1'b1, 3'd2, 8'h30, 8'h00, 3'd3, 8'h34, 1'b1}, // R4 set keeps others
    '{1'b1, 3'd3, 8'h14, 8'h00, 3'd2, 8'h20, 1'b0}, // R5
    '{1'b0, 3'd0, 8'h00, 8'h20, 3'd1, 8'h20, 1'b1}, // R3 R9
    '{1'b1, 3'd1, 8'h20, 8'h00, 3'd0, 8'h05, 1'b0}, // R6
    '{1'b1, 3'd4, 8'hA5, 8'h00, 3'd4, 8'hA5, 1'b0}, // R8
    '{1'b0, 3'd0, 8'h00, 8'h00, 3'd2, 8'h20, 1'b0}, // R8 enables untouched
    '{1'b1, 3'd0, 8'hFF, 8'h00, 3'd0, 8'h05, 1'b0}, // R10 raw is read-only
    '{1'b1, 3'd6, 8'hFF, 8'h00, 3'd6, 8'h00, 1'b0}, // R10 hole
    '{1'b1, 3'd1, 8'h04, 8'h04, 3'd0, 8'h05, 1'b0}, // R7 event wins
    '{1'b1, 3'd1, 8'h05, 8'h00, 3'd0, 8'h00, 1'b0}, // R6 full clear
    '{1'b1, 3'd2, 8'hFF, 8'h80, 3'd1, 8'h80, 1'b1}  // R3 R9
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, then set the read address and sample mid-cycle
  task automatic cycle(input logic we, input logic [2:0] wa, input logic [DW-1:0] wd,
                       input logic [NE-1:0] ev, input logic fd, input logic [2:0] ra);
    @(negedge clk);
    wrEn = we; addr = wa; wrData = wd; evtPulse = ev; frameDone = fd;
    @(posedge clk);
    #0.5;
    wrEn = 1'b0; evtPulse = '0; frameDone = 1'b0; addr = ra; wrData = '0;
    #0.5;
  endtask

  task automatic readAt(input logic [2:0] ra, input string req, input logic [DW-1:0] exp);
    addr = ra;
    #0.2;
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) readAt(3'(a), "R1", '0);
    check("R1 irq", {31'b0, irqOut}, '0);

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].we, VECS[i].wa, {24'b0, VECS[i].wd}, VECS[i].ev, 1'b0, VECS[i].ra);
      check($sformatf("vec%0d rd", i), rdData, {24'b0, VECS[i].expRd});
      check($sformatf("vec%0d R9 irq", i), {31'b0, irqOut}, {31'b0, VECS[i].expIrq});
    end

    // R10 upper data bits ignored and read zero
    cycle(1'b1, 3'd3, 32'hFFFF_FFFF, '0, 1'b0, 3'd2);
    check("R10 upper bits", rdData, 32'h0);
    cycle(1'b1, 3'd2, 32'hFFFF_FF01, '0, 1'b0, 3'd3);
    check("R10 masked set", rdData, 32'h01);
    cycle(1'b1, 3'd1, 32'hFFFF_FFFF, '0, 1'b0, 3'd0);
    check("R6 clear all", rdData, 32'h0);

    // R11 frame done port lands on bit 0 and raises the interrupt
    cycle(1'b0, 3'd0, '0, '0, 1'b1, 3'd0);
    check("R11 raw", rdData, 32'h01);
    check("R11 irq", {31'b0, irqOut}, 32'h1);

    // R8 wake write keeps irq and raw
    cycle(1'b1, 3'd4, 32'h0000_003C, '0, 1'b0, 3'd4);
    check("R8 wake", rdData, 32'h3C);
    check("R8 irq kept", {31'b0, irqOut}, 32'h1);
    readAt(3'd0, "R8 raw kept", 32'h01);

    // R1 reset mid-run clears everything
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 rstN = 1'b1;
    readAt(3'd0, "R1 raw", '0);
    readAt(3'd2, "R1 en", '0);
    readAt(3'd4, "R1 wake", '0);
    check("R1 irq after reset", {31'b0, irqOut}, '0);

    doneFlag = 1'b1;
  end

  initial begin
    fork
      wait (doneFlag);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule